// File: doc/BRIEF.md
# Four-Level Clock Power Mode Controller

This controller moves a small processor-style subsystem through four nested power levels: full operation, doze, nap and sleep. Each deeper level stops one more clock domain. Doze stops the execution-unit clock. Nap also stops the bus-interface clock. Sleep also stops the clock generator, and a configuration input chooses whether the PLL keeps running in sleep or is switched off. Software selects a level with a one-cycle request strobe. The controller then steps the three clock enables one domain per cycle, so clocks are always stopped and restarted in a fixed order.

A small always-on wake detector combines the interrupt lines and a dedicated wake pin. Any event on them returns the subsystem to full operation, whatever level it was in. If the PLL was switched off, the clock generator is held off for a programmable lock time after the PLL is restarted. An idle timer runs only in full operation and restarts on any activity. After a programmable number of consecutive quiet cycles it drops the subsystem into a configured low-power level on its own.

Top module: `pmc_top`

## Requirements
- R1: During and after reset, mode_o is 00 (full), exec_clk_en, bus_clk_en and gen_clk_en are all 1, and pll_en is 1.
- R2: A request (req_valid high) sampled at a clock edge with no wake event sets mode_o to req_mode right after that edge. The codes are 00 full, 01 doze, 10 nap and 11 sleep. The first change to the clock enables also follows that same edge.
- R3: Once settled, the enables for each mode are as follows. Full has all three at 1. Doze has exec 0. Nap has exec and bus 0. Sleep has all three at 0. An enable is never 1 while a domain it depends on (bus for exec, generator for bus) is 0.
- R4: On the way down, domains stop one per clock: execution, then bus, then generator.
- R5: On the way up, domains restart one per clock: generator, then bus, then execution.
- R6: In sleep with pll_keep low, pll_en falls at the same edge as gen_clk_en. With pll_keep high, pll_en stays 1 throughout sleep.
- R7: Suppose a wake event is sampled at edge W while in sleep with the PLL stopped. Then pll_en rises after W, and gen_clk_en stays 0 until edge W+lock_cycles+1, when it rises.
- R8: A wake event sampled at edge W in sleep with the PLL running raises gen_clk_en right after W.
- R9: A wake event (any irq bit or wake_pin high) sampled at an edge makes mode_o 00 after that edge from any mode. It takes priority over a request or idle expiry in the same cycle.
- R10: In full mode with idle_limit nonzero, the idle_limit-th consecutive quiet edge sets mode_o to idle_mode. With idle_limit zero the timer never fires.
- R11: A cycle with activity, req_valid or a wake event high restarts the quiet-cycle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Software mode request strobe |
| req_mode | input | 2 | Requested mode code |
| pll_keep | input | 1 | Keep PLL running while in sleep |
| irq | input | N_IRQ | Interrupt lines watched by the wake detector |
| wake_pin | input | 1 | Dedicated wake input |
| activity | input | 1 | Subsystem busy indication for the idle timer |
| idle_limit | input | IDLE_W | Quiet cycles before static shutdown, 0 disables |
| idle_mode | input | 2 | Mode entered on idle expiry |
| lock_cycles | input | LOCK_W | PLL lock wait after restart |
| mode_o | output | 2 | Current target mode |
| exec_clk_en | output | 1 | Execution-unit clock enable |
| bus_clk_en | output | 1 | Bus-interface clock enable |
| gen_clk_en | output | 1 | Clock-generator enable |
| pll_en | output | 1 | PLL run control |

## Verification
A wake event can arrive in the same cycle as a software request or the idle expiry. It can also arrive while clocks are still being stepped down, or during the PLL lock wait. The bench provokes the request collision directly: it raises wake_pin and req_valid together while in nap and expects full mode. The other collisions come from random traffic with short idle limits and short lock times. A cycle-level model in the bench predicts every output on every cycle, so any ordering or priority slip shows up as a mismatch in mode_o, an enable or pll_en.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_FULL  = 2'b00,
    PM_DOZE  = 2'b01,
    PM_NAP   = 2'b10,
    PM_SLEEP = 2'b11
  } pm_mode_e;

  localparam logic [1:0] LVL_MAX = 2'd3;

  // Level = number of stopped domains; mode code equals its level.
  function automatic logic [1:0] lvl_step(input logic [1:0] cur,
                                          input logic [1:0] tgt,
                                          input logic up_ok);
    logic [1:0] nxt;
    nxt = cur;
    if (cur < tgt)                nxt = cur + 2'd1;
    else if (cur > tgt && up_ok)  nxt = cur - 2'd1;
    return nxt;
  endfunction

  // Returns {gen, bus, exec} enables for a level.
  function automatic logic [2:0] lvl_enables(input logic [1:0] lvl);
    logic [2:0] en;
    en[0] = (lvl < 2'd1);
    en[1] = (lvl < 2'd2);
    en[2] = (lvl < 2'd3);
    return en;
  endfunction

  function automatic logic [1:0] pick_target(input logic wake,
                                             input logic req,
                                             input logic [1:0] req_mode,
                                             input logic idle_hit,
                                             input logic [1:0] idle_mode,
                                             input logic [1:0] cur);
    logic [1:0] t;
    if (wake)          t = PM_FULL;
    else if (req)      t = req_mode;
    else if (idle_hit) t = idle_mode;
    else               t = cur;
    return t;
  endfunction

endpackage

// File: rtl/pmc_wake_det.sv
module pmc_wake_det #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq,
  input  logic             wake_pin,
  output logic             wake_any
);
  logic [N_IRQ:0] chain;

  assign chain[0] = wake_pin;
  for (genvar i = 0; i < N_IRQ; i++) begin : g_or
    assign chain[i+1] = chain[i] | irq[i];
  end
  assign wake_any = chain[N_IRQ];

endmodule

// File: rtl/pmc_idle_timer.sv
module pmc_idle_timer #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              quiet,
  input  logic [IDLE_W-1:0] limit,
  output logic              hit
);
  logic [IDLE_W-1:0] cnt_q;
  logic [IDLE_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + {{(IDLE_W-1){1'b0}}, 1'b1};
  assign hit     = count_en && quiet && (limit != '0) && (cnt_inc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (!count_en || !quiet || hit) cnt_q <= '0;
    else                                 cnt_q <= cnt_inc;
  end

endmodule

// File: rtl/pmc_level_seq.sv
module pmc_level_seq #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tgt_nxt,
  input  logic              pll_keep,
  input  logic [LOCK_W-1:0] lock_cycles,
  output logic [1:0]        lvl_q,
  output logic              pll_q,
  output logic              leave_sleep,
  output logic              relock
);
  import pmc_pkg::*;

  logic [LOCK_W-1:0] settle_q;
  logic [LOCK_W-1:0] settle_d;
  logic [1:0]        lvl_d;
  logic              pll_d;
  logic              up_ok;

  assign leave_sleep = (lvl_q == LVL_MAX) && (tgt_nxt != LVL_MAX);
  assign relock      = leave_sleep && !pll_q;
  assign up_ok       = !((lvl_q == LVL_MAX) && (!pll_q || settle_q != '0));

  always_comb begin
    lvl_d = lvl_step(lvl_q, tgt_nxt, up_ok);

    if (tgt_nxt == LVL_MAX)   settle_d = '0;
    else if (relock)          settle_d = lock_cycles;
    else if (settle_q != '0)  settle_d = settle_q - {{(LOCK_W-1){1'b0}}, 1'b1};
    else                      settle_d = '0;

    if (tgt_nxt == LVL_MAX && lvl_d == LVL_MAX && !pll_keep) pll_d = 1'b0;
    else if (leave_sleep)                                    pll_d = 1'b1;
    else                                                     pll_d = pll_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= 2'd0;
      pll_q    <= 1'b1;
      settle_q <= '0;
    end else begin
      lvl_q    <= lvl_d;
      pll_q    <= pll_d;
      settle_q <= settle_d;
    end
  end

endmodule

// File: rtl/pmc_top.sv
module pmc_top #(
  parameter int N_IRQ  = 4,
  parameter int IDLE_W = 16,
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              pll_keep,
  input  logic [N_IRQ-1:0]  irq,
  input  logic              wake_pin,
  input  logic              activity,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [1:0]        idle_mode,
  input  logic [LOCK_W-1:0] lock_cycles,
  output logic [1:0]        mode_o,
  output logic              exec_clk_en,
  output logic              bus_clk_en,
  output logic              gen_clk_en,
  output logic              pll_en
);
  import pmc_pkg::*;

  logic       wake_any;
  logic       idle_hit;
  logic       quiet;
  logic [1:0] tgt_q;
  logic [1:0] tgt_nxt;
  logic [1:0] lvl;
  logic       pll_run;
  logic       leave_sleep;
  logic       relock;
  logic [2:0] en_vec;

  pmc_wake_det #(.N_IRQ(N_IRQ)) u_wake (
    .irq      (irq),
    .wake_pin (wake_pin),
    .wake_any (wake_any)
  );

  assign quiet = !(wake_any || req_valid || activity);

  pmc_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (tgt_q == PM_FULL),
    .quiet    (quiet),
    .limit    (idle_limit),
    .hit      (idle_hit)
  );

  assign tgt_nxt = pick_target(wake_any, req_valid, req_mode, idle_hit, idle_mode, tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= PM_FULL;
    else        tgt_q <= tgt_nxt;
  end

  pmc_level_seq #(.LOCK_W(LOCK_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_nxt     (tgt_nxt),
    .pll_keep    (pll_keep),
    .lock_cycles (lock_cycles),
    .lvl_q       (lvl),
    .pll_q       (pll_run),
    .leave_sleep (leave_sleep),
    .relock      (relock)
  );

  assign en_vec      = lvl_enables(lvl);
  assign exec_clk_en = en_vec[0];
  assign bus_clk_en  = en_vec[1];
  assign gen_clk_en  = en_vec[2];
  assign pll_en      = pll_run;
  assign mode_o      = tgt_q;

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_mode,
  input logic       wake_any,
  input logic [1:0] mode_o,
  input logic       exec_clk_en,
  input logic       bus_clk_en,
  input logic       gen_clk_en,
  input logic       pll_en
);
  AST_NESTED_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_clk_en -> bus_clk_en) && (bus_clk_en -> gen_clk_en)); // R3

  AST_ONE_DOMAIN_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({exec_clk_en, bus_clk_en, gen_clk_en} ^
               $past({exec_clk_en, bus_clk_en, gen_clk_en})) <= 1); // R4

  AST_GEN_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    gen_clk_en |-> pll_en); // R6

  AST_REQ_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wake_any) |=> (mode_o == $past(req_mode))); // R2

  AST_WAKE_TO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wake_any |=> (mode_o == 2'b00)); // R9

  AST_RELOCK_HOLDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> !gen_clk_en); // R7
endmodule

bind pmc_top pmc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_mode    (req_mode),
  .wake_any    (wake_any),
  .mode_o      (mode_o),
  .exec_clk_en (exec_clk_en),
  .bus_clk_en  (bus_clk_en),
  .gen_clk_en  (gen_clk_en),
  .pll_en      (pll_en)
);

// File: tb/tb_pmc_top.sv
module tb_pmc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int IW = 16;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_mode = 2'b00;
  logic          pll_keep = 1'b0;
  logic [NI-1:0] irq = '0;
  logic          wake_pin = 1'b0;
  logic          activity = 1'b0;
  logic [IW-1:0] idle_limit = '0;
  logic [1:0]    idle_mode = 2'b00;
  logic [LW-1:0] lock_cycles = '0;
  logic [1:0]    mode_o;
  logic          exec_clk_en, bus_clk_en, gen_clk_en, pll_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model state
  logic [1:0]    m_tgt;
  int            m_lvl;
  logic          m_pll;
  int            m_settle;
  int            m_icnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_top #(.N_IRQ(NI), .IDLE_W(IW), .LOCK_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .pll_keep(pll_keep), .irq(irq), .wake_pin(wake_pin), .activity(activity),
    .idle_limit(idle_limit), .idle_mode(idle_mode), .lock_cycles(lock_cycles),
    .mode_o(mode_o), .exec_clk_en(exec_clk_en), .bus_clk_en(bus_clk_en),
    .gen_clk_en(gen_clk_en), .pll_en(pll_en)
  );

  function automatic logic [2:0] exp_en(input int lvl);
    case (lvl)
      0: return 3'b111;
      1: return 3'b110;
      2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_tgt = 2'b00; m_lvl = 0; m_pll = 1'b1; m_settle = 0; m_icnt = 0;
  endtask

  task automatic model_edge();
    logic w, q, hit, lsl;
    logic [1:0] nt;
    int nl, ns;
    logic np;
    w   = (|irq) || wake_pin;
    q   = !(w || req_valid || activity);
    hit = (m_tgt == 2'b00) && q && (idle_limit != 0) && (m_icnt + 1 == int'(idle_limit));
    nt  = w ? 2'b00 : (req_valid ? req_mode : (hit ? idle_mode : m_tgt));
    lsl = (m_lvl == 3) && (nt != 2'b11);
    nl = m_lvl;
    if (m_lvl < int'(nt)) nl = m_lvl + 1;
    else if (m_lvl > int'(nt) && !(m_lvl == 3 && (!m_pll || m_settle != 0))) nl = m_lvl - 1;
    if (nt == 2'b11) ns = 0;
    else if (lsl && !m_pll) ns = int'(lock_cycles);
    else if (m_settle > 0) ns = m_settle - 1;
    else ns = 0;
    np = m_pll;
    if (nt == 2'b11 && nl == 3 && !pll_keep) np = 1'b0;
    else if (lsl) np = 1'b1;
    m_icnt = (m_tgt != 2'b00 || !q || hit) ? 0 : m_icnt + 1;
    m_tgt = nt; m_lvl = nl; m_settle = ns; m_pll = np;
  endtask

  // one clock: model steps with the inputs seen at the edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(mode_o == m_tgt, "R2/R9/R10 mode_o", mode_o, m_tgt);
    chk({gen_clk_en, bus_clk_en, exec_clk_en} == exp_en(m_lvl), "R3/R4/R5 enables",
        {gen_clk_en, bus_clk_en, exec_clk_en}, exp_en(m_lvl));
    chk(pll_en == m_pll, "R6/R7 pll_en", pll_en, m_pll);
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; irq = '0; wake_pin = 1'b0; activity = 1'b0;
  endtask

  task automatic enables_are(input logic [2:0] e, input string tag);
    chk({gen_clk_en, bus_clk_en, exec_clk_en} == e, tag,
        {gen_clk_en, bus_clk_en, exec_clk_en}, e);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : main
    int w0;
    void'($urandom(32'h1234_5678));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mode_o == 2'b00, "R1 mode at reset", mode_o, 0);
    enables_are(3'b111, "R1 enables at reset");
    chk(pll_en == 1'b1, "R1 pll at reset", pll_en, 1);
    rst_n = 1'b1;
    cyc();

    // R2, R4, R6: request sleep with PLL stop
    pll_keep = 1'b0; lock_cycles = 8'd5;
    req_valid = 1'b1; req_mode = 2'b11;
    cyc(); idle_inputs();
    chk(mode_o == 2'b11, "R2 mode after request", mode_o, 3);
    enables_are(3'b110, "R4 exec stops first");
    cyc(); enables_are(3'b100, "R4 bus stops second");
    chk(pll_en == 1'b1, "R6 pll before gen stop", pll_en, 1);
    cyc(); enables_are(3'b000, "R4 gen stops third");
    chk(pll_en == 1'b0, "R6 pll stops with gen", pll_en, 0);
    cyc();

    // R7, R5: wake with relock of 5 cycles
    wake_pin = 1'b1;
    cyc(); idle_inputs();
    chk(mode_o == 2'b00, "R9 wake to full", mode_o, 0);
    chk(pll_en == 1'b1, "R7 pll restarts", pll_en, 1);
    enables_are(3'b000, "R7 gen held at wake");
    for (int k = 1; k <= 5; k++) begin
      cyc(); enables_are(3'b000, "R7 gen held during lock");
    end
    cyc(); enables_are(3'b100, "R7 gen after lock");
    cyc(); enables_are(3'b110, "R5 bus second");
    cyc(); enables_are(3'b111, "R5 exec last");

    // R8: sleep with PLL kept, wake restores gen at once
    pll_keep = 1'b1; req_valid = 1'b1; req_mode = 2'b11;
    cyc(); idle_inputs();
    repeat (3) cyc();
    chk(pll_en == 1'b1, "R6 pll kept in sleep", pll_en, 1);
    irq[2] = 1'b1;
    cyc(); idle_inputs();
    enables_are(3'b100, "R8 gen right after wake");
    repeat (2) cyc();

    // R9: wake beats request in nap
    req_valid = 1'b1; req_mode = 2'b10;
    cyc(); idle_inputs(); cyc();
    req_valid = 1'b1; req_mode = 2'b01; wake_pin = 1'b1;
    cyc(); idle_inputs();
    chk(mode_o == 2'b00, "R9 wake wins over request", mode_o, 0);
    repeat (2) cyc();

    // R10, R11: idle limit 10 into nap, with an activity pulse in the middle
    idle_limit = 16'd10; idle_mode = 2'b10;
    activity = 1'b1; cyc(); activity = 1'b0;
    repeat (6) cyc();
    activity = 1'b1; cyc(); activity = 1'b0;
    for (int k = 1; k <= 9; k++) cyc();
    chk(mode_o == 2'b00, "R11 count restarted by activity", mode_o, 0);
    cyc();
    chk(mode_o == 2'b10, "R10 idle expiry enters nap", mode_o, 2);
    wake_pin = 1'b1; cyc(); idle_inputs(); repeat (2) cyc();

    // R10: zero limit never fires
    idle_limit = '0;
    repeat (300) cyc();
    chk(mode_o == 2'b00, "R10 zero limit disabled", mode_o, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      w0 = int'($urandom_range(0, 99));
      req_valid = (w0 < 8);
      req_mode  = 2'($urandom_range(0, 3));
      wake_pin  = (w0 >= 8 && w0 < 12);
      irq       = (w0 == 12) ? NI'(1 << $urandom_range(0, NI-1)) : '0;
      activity  = ($urandom_range(0, 15) == 0);
      if (n % 200 == 0) begin
        idle_limit  = IW'($urandom_range(0, 12));
        idle_mode   = 2'($urandom_range(1, 3));
        lock_cycles = LW'($urandom_range(0, 6));
      end
      if (req_valid) pll_keep = 1'($urandom_range(0, 1));
      cyc();
    end
    idle_inputs();
    cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule